// File: doc/BRIEF.md
# Quadrature Transition Counter

This block watches a two-channel quadrature signal (channels A and B, square waves a quarter period apart whose period and direction may change at any time) and keeps one counter for each of the eight legal moves between adjacent quadrature phases. The four forward moves each have their own incrementing counter. The four backward moves each have their own decrementing counter. As a result, a downstream consumer can see how often each individual edge was crossed in each direction, and not only a net position.

Both channels are first brought into the system clock domain through a chain of flip-flops. The block then compares the synchronized sample with the previous one. A change in exactly one channel is classified against the stored phase and counts as a single event. A change in both channels in the same cycle cannot be assigned a direction. It is rejected and reported on an error pulse. All eight counter values are driven out continuously with no handshake, because there is nothing to back-pressure: each value is a level and is valid in every cycle after reset.

Top module: `qdr_step_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter is loaded with 2^(CNT_W-2) (16777216 for 26 bits) and `jump_err_o` is driven low.
- R2: Phases are coded from {A,B} as 00 = phase index 0, 01 = index 1, 11 = index 2, 10 = index 3. A single-channel change from index k to index (k+1) mod 4 increments counter slot k by one.
- R3: A single-channel change from index k to index (k+3) mod 4 decrements counter slot 4 + ((k+3) mod 4) by one. Slot 4 counts 1->0, slot 5 counts 2->1, slot 6 counts 3->2, and slot 7 counts 0->3.
- R4: A change on the inputs appears on `count_o` at the third rising edge after it is sampled. That is two synchronizer stages plus one counting register. No other slot changes in that cycle.
- R5: On reset the stored phase is taken from the synchronized input levels, so releasing reset never counts an event by itself.
- R6: If both channels change in the same synchronized sample, no counter changes, the stored phase is kept, and `jump_err_o` is high for exactly one cycle, with the same latency as R4.
- R7: After such a jump, the next single-channel change is classified from the last accepted phase to the new level. A forward neighbour counts as in R2 and a backward neighbour counts as in R3.
- R8: Counters wrap modulo 2^CNT_W in both directions without saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| quad_a | input | 1 | Channel A, asynchronous |
| quad_b | input | 1 | Channel B, asynchronous |
| count_o | output | 8 x CNT_W | Per-transition counters; slots 0..3 forward, 4..7 backward |
| jump_err_o | output | 1 | One-cycle pulse on a rejected double-channel change |

## Verification
If the stored phase were wrong, the very next single-channel edge would land in the wrong slot or in no slot at all. That mismatch is visible on `count_o` three cycles after the edge arrives. A slip in the previous-sample register shows up in the same cycle as a phantom count or a spurious `jump_err_o`. Counter width faults stay hidden until a wrap, so a narrow instance is walked across both wrap boundaries.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  localparam int N_PHASE  = 4;
  localparam int N_EVT    = 2 * N_PHASE;
  localparam int FWD_BASE = 0;
  localparam int REV_BASE = N_PHASE;

  typedef logic [1:0] phase_t;

  // {A,B} Gray level to phase index: 00->0, 01->1, 11->2, 10->3
  function automatic phase_t phase_of(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/qdr_sync.sv
module qdr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) stage[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) stage[g] <= stage[g-1];
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/qdr_phase_tracker.sv
module qdr_phase_tracker
  import qdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ab_s,
  output logic [N_EVT-1:0] evt,
  output logic             jump
);

  phase_t     phase_q, phase_d, new_ph;
  logic [1:0] ab_q, diff;

  always_comb begin
    diff    = ab_s ^ ab_q;
    new_ph  = phase_of(ab_s);
    evt     = '0;
    jump    = 1'b0;
    phase_d = phase_q;
    case (diff)
      2'b01, 2'b10: begin
        phase_d = new_ph;
        if (new_ph == phase_t'(phase_q + 2'd1))
          evt[FWD_BASE + int'(phase_q)] = 1'b1;
        else if (new_ph == phase_t'(phase_q - 2'd1))
          evt[REV_BASE + int'(new_ph)] = 1'b1;
      end
      2'b11:   jump = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    ab_q <= ab_s;
    if (rst) phase_q <= phase_of(ab_s);
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/qdr_event_counter.sv
module qdr_event_counter #(
  parameter int           W        = 26,
  parameter bit           COUNT_UP = 1'b1,
  parameter logic [W-1:0] PRESET   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  if (COUNT_UP) begin : g_up
    assign nxt = q + W'(1);
  end else begin : g_down
    assign nxt = q - W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= PRESET;
    else if (hit) q <= nxt;
  end

endmodule

// File: rtl/qdr_step_counter.sv
module qdr_step_counter
  import qdr_pkg::*;
#(
  parameter int CNT_W       = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        quad_a,
  input  logic                        quad_b,
  output logic [N_EVT-1:0][CNT_W-1:0] count_o,
  output logic                        jump_err_o
);

  localparam logic [CNT_W-1:0] PRESET = CNT_W'(1) << (CNT_W - 2);

  logic [1:0]       ab_s;
  logic [N_EVT-1:0] evt;
  logic             jump;

  qdr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({quad_a, quad_b}),
    .q   (ab_s)
  );

  qdr_phase_tracker u_track (
    .clk  (clk),
    .rst  (rst),
    .ab_s (ab_s),
    .evt  (evt),
    .jump (jump)
  );

  for (genvar i = 0; i < N_EVT; i++) begin : g_cnt
    qdr_event_counter #(
      .W        (CNT_W),
      .COUNT_UP (i < REV_BASE),
      .PRESET   (PRESET)
    ) u_cnt (
      .clk (clk),
      .rst (rst),
      .hit (evt[i]),
      .q   (count_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) jump_err_o <= 1'b0;
    else     jump_err_o <= jump;
  end

endmodule

// File: rtl/qdr_step_checker.sv
module qdr_step_checker
  import qdr_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_EVT-1:0][CNT_W-1:0] count_o,
  input logic                        jump_err_o
);

  localparam logic [CNT_W-1:0] PRESET = CNT_W'(1) << (CNT_W - 2);

  logic [N_EVT-1:0][CNT_W-1:0] prev;
  logic                        prev_ok;
  logic [N_EVT-1:0]            chg;

  always_ff @(posedge clk) begin
    prev    <= count_o;
    prev_ok <= !rst;
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_slot
    assign chg[i] = prev_ok && (count_o[i] != prev[i]);

    p_preset_r1: assert property (@(posedge clk) disable iff (rst)
      !prev_ok |-> count_o[i] == PRESET);

    if (i < REV_BASE) begin : g_fwd
      p_fwd_step_r2: assert property (@(posedge clk) disable iff (rst)
        chg[i] |-> count_o[i] == CNT_W'(prev[i] + CNT_W'(1)));
    end else begin : g_rev
      p_rev_step_r3: assert property (@(posedge clk) disable iff (rst)
        chg[i] |-> count_o[i] == CNT_W'(prev[i] - CNT_W'(1)));
    end
  end

  p_err_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !prev_ok |-> !jump_err_o);

  p_one_slot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);

  p_jump_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    jump_err_o |-> chg == '0);

  p_jump_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    jump_err_o |=> !jump_err_o);

endmodule

bind qdr_step_counter qdr_step_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .count_o    (count_o),
  .jump_err_o (jump_err_o)
);

// File: tb/tb_qdr_step_counter.sv
module tb_qdr_step_counter;

  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quad_a = 1'b1;
  logic quad_b = 1'b1;
  logic [NE-1:0][25:0] cw;
  logic [NE-1:0][2:0]  cn;
  logic err_w, err_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qdr_step_counter dut (
    .clk(clk), .rst(rst), .quad_a(quad_a), .quad_b(quad_b),
    .count_o(cw), .jump_err_o(err_w));

  qdr_step_counter #(.CNT_W(3)) dut_narrow (
    .clk(clk), .rst(rst), .quad_a(quad_a), .quad_b(quad_b),
    .count_o(cn), .jump_err_o(err_n));

  typedef struct {
    int                  due;
    logic [NE-1:0][25:0] w;
    logic [NE-1:0][2:0]  n;
    logic                err;
    string               tag;
  } item_t;

  item_t sb_q[$];

  int         net [NE];
  int         mph;
  logic [1:0] ms;

  function automatic item_t snap(input int due, input logic e, input string tag);
    item_t it;
    it.due = due; it.err = e; it.tag = tag;
    for (int i = 0; i < NE; i++) begin
      it.w[i] = 26'(32'h0100_0000 + net[i]);
      it.n[i] = 3'(2 + net[i]);
    end
    return it;
  endfunction

  task automatic compare(input item_t it);
    string msg;
    bit bad;
    bad = 1'b0;
    checks++;
    for (int i = 0; i < NE; i++) begin
      if (!bad && cw[i] !== it.w[i]) begin
        bad = 1'b1;
        msg = $sformatf("slot %0d wide actual=%0d expected=%0d", i, cw[i], it.w[i]);
      end
      if (!bad && cn[i] !== it.n[i]) begin
        bad = 1'b1;
        msg = $sformatf("slot %0d narrow actual=%0d expected=%0d", i, cn[i], it.n[i]);
      end
    end
    if (!bad && (err_w !== it.err || err_n !== it.err)) begin
      bad = 1'b1;
      msg = $sformatf("jump_err actual=%b/%b expected=%b", err_w, err_n, it.err);
    end
    if (bad) begin
      failures++;
      $display("FAIL %s: %s (cycle %0d)", it.tag, msg, cyc);
    end
  endtask

  // monitor: pops scoreboard items when their cycle arrives
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) compare(sb_q.pop_front());
  end

  // driver: apply one level change, push expected results
  task automatic step(input logic a, input logic b, input string tag);
    logic [1:0] ns, d;
    int np, c;
    logic e;
    @(negedge clk);
    c = cyc;
    sb_q.push_back(snap(c + 2, 1'b0, "R4 latency (no change yet)"));
    quad_a = a; quad_b = b;
    ns = {a, b};
    d  = ns ^ ms;
    e  = 1'b0;
    if (d == 2'b01 || d == 2'b10) begin
      np = int'({a, a ^ b});
      if (np == (mph + 1) % 4)      net[mph]++;
      else if (np == (mph + 3) % 4) net[4 + np]--;
      mph = np;
    end else if (d == 2'b11) begin
      e = 1'b1;
    end
    ms = ns;
    sb_q.push_back(snap(c + 3, e, tag));
    sb_q.push_back(snap(c + 4, 1'b0, e ? "R6 pulse width" : tag));
    repeat (6) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NE; i++) net[i] = 0;
    ms  = {quad_a, quad_b};
    mph = int'({quad_a, quad_a ^ quad_b});
  endtask

  task automatic direct(input string tag);
    compare(snap(cyc, 1'b0, tag));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    model_reset();
    repeat (6) @(negedge clk);
    rst = 1'b0;
    direct("R1 reset preset");
    repeat (5) @(negedge clk);
    direct("R5 no count on reset release");

    // forward walk from 11: six full rotations, narrow forward slots wrap 7->0
    for (int r = 0; r < 6; r++) begin
      step(1'b1, 1'b0, "R2 forward 2->3");
      step(1'b0, 1'b0, "R2 forward 3->0");
      step(1'b0, 1'b1, "R2 forward 0->1");
      step(1'b1, 1'b1, "R2 R8 forward 1->2");
    end
    // reverse walk from 11: three rotations, narrow reverse slots wrap 0->7
    for (int r = 0; r < 3; r++) begin
      step(1'b0, 1'b1, "R3 reverse 2->1");
      step(1'b0, 1'b0, "R3 reverse 1->0");
      step(1'b1, 1'b0, "R3 R8 reverse 0->3");
      step(1'b1, 1'b1, "R3 reverse 3->2");
    end
    // direction reversals
    step(1'b1, 1'b0, "R2 forward before reversal");
    step(1'b1, 1'b1, "R3 reversal");
    step(1'b1, 1'b0, "R2 re-reversal");
    step(1'b0, 1'b0, "R2 forward 3->0");
    step(1'b1, 1'b0, "R3 reverse 0->3");
    // double-channel jumps
    step(1'b0, 1'b1, "R6 jump 10->01");
    step(1'b0, 1'b0, "R7 forward from kept phase 3");
    step(1'b1, 1'b1, "R6 jump 00->11");
    step(1'b1, 1'b0, "R7 reverse from kept phase 0");

    // reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    direct("R1 preset after mid-run reset");
    repeat (5) @(negedge clk);
    direct("R5 level 10 held through reset");
    step(1'b0, 1'b0, "R5 R2 first edge after reset");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule